// File: doc/BRIEF.md
# Broadcast Multiply-Accumulate Array for Serial Input Vectors

This block forms several dot products at once from an input vector that arrives one element per accepted cycle. Every accepted element goes to all lanes in the same cycle. Each lane multiplies it by the weight that its own local weight store keeps for that element position, and adds the product to a private running sum. The block has one multiplier per output rather than one per input. That keeps the multiplier count small when vectors are very long, at the cost of one pass over the vector for each set of results.

After the last element of a vector is accepted, every lane's total appears together on a wide result bus, with a one-cycle valid pulse. Accumulation restarts directly with the first element of the following vector, so vectors may follow one another with no idle cycle. The sample valid may drop between elements. Accumulation then simply waits. Weights are written one word at a time through a separate write port that selects a lane and an element position.

Top module: `tmi_mac_array`

## Requirements
- R1: While `rstN` is low, and after any reset, `resValid` is 0, `resData` is all zeros, and the element position counter is back at position 0, so the next accepted sample is element 0 of a new vector.
- R2: A cycle with `wrEn` high stores `wrData` as the weight of lane `wrLane` for element position `wrAddr`. It affects no other lane or position. The new value is used only for samples accepted after that clock edge; a sample accepted on the same edge still uses the old weight.
- R3: For each lane l, the result equals the exact signed sum over k of x[k]·w[l][k], where x[k] is the k-th accepted sample of the vector and w[l][k] is lane l's weight for position k. Inputs and weights are two's complement.
- R4: `resValid` is high for exactly one cycle. That cycle is the one right after the edge that accepts the NUM_IN-th sample of a vector. In that same cycle lane l's total is on `resData[l*ACC_W +: ACC_W]`, with ACC_W = DATA_W + WGT_W + clog2(NUM_IN).
- R5: `resData` keeps its value until the next result is presented.
- R6: Cycles with `inValid` low between samples of a vector pause accumulation and change no result.
- R7: The first sample of the next vector may be accepted in the cycle straight after the last sample of the previous one. Its result then depends on its own samples only.
- R8: The accumulator width holds extreme operands without wrapping. Every sample and every weight at -2^(DATA_W-1) gives NUM_IN·2^(DATA_W+WGT_W-2). A maximum positive sample against the most negative weight gives a correct negative sum.
- R9: `inData` is ignored in cycles with `inValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample on `inData` is accepted at this edge |
| inData | input | DATA_W | Signed input sample, broadcast to all lanes |
| wrEn | input | 1 | Weight write strobe |
| wrLane | input | clog2(NUM_LANES) | Lane selected for the weight write |
| wrAddr | input | clog2(NUM_IN) | Element position of the weight written |
| wrData | input | WGT_W | Signed weight value |
| resValid | output | 1 | One-cycle pulse: a complete set of results is on `resData` |
| resData | output | NUM_LANES*ACC_W | Lane totals, lane l at bits l*ACC_W upward |

## Verification
Each sample passes through exactly one register, the lane accumulator or the result register. The totals and the valid pulse therefore appear in the cycle after the edge that accepts the last sample. The bench drives each sample at a falling edge and reads the outputs at the following falling edge. It expects `resValid` low at every intermediate sample and high with the full totals right after the last one. For weight writes, the bench applies the one-edge rule of R2: a write on the edge that consumes the same position is expected to have no effect on the running vector and to show in the next one. Hold and ignore behaviour is read at falling edges during idle stretches.

// File: rtl/tmi_pkg.sv
package tmi_pkg;

  // Strobes from the sequencer to every lane, valid for the current cycle.
  typedef struct packed {
    logic accept;   // a sample is taken at this edge
    logic first;    // the sample is element 0: restart the running sum
    logic last;     // the sample is the final element: capture the total
  } ctrlStrobes_t;

endpackage

// File: rtl/tmi_ctrl.sv
module tmi_ctrl
  import tmi_pkg::*;
#(
  parameter int NUM_IN = 256,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output ctrlStrobes_t     strb,
  output logic [IDX_W-1:0] idx,
  output logic             resValid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IN - 1);

  logic atLast;

  assign atLast      = (idx == LAST_IDX);
  assign strb.accept = inValid;
  assign strb.first  = inValid && (idx == '0);
  assign strb.last   = inValid && atLast;

  // Element position; wraps to 0 after the final element so that the next
  // vector may start in the very next cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (inValid) begin
      idx <= atLast ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
    end else begin
      resValid <= strb.last;
    end
  end

endmodule

// File: rtl/tmi_lane.sv
module tmi_lane
  import tmi_pkg::*;
#(
  parameter int NUM_IN = 256,
  parameter int DATA_W = 8,
  parameter int WGT_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IN),
  localparam int PROD_W = DATA_W + WGT_W,
  localparam int ACC_W  = PROD_W + IDX_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strb,
  input  logic [IDX_W-1:0]         idx,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     wrEn,
  input  logic [IDX_W-1:0]         wrAddr,
  input  logic signed [WGT_W-1:0]  wrData,
  output logic signed [ACC_W-1:0]  result
);

  logic signed [WGT_W-1:0]  wMem [NUM_IN];
  logic signed [WGT_W-1:0]  wRead;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accNext;

  // Weight store: write at the edge, read combinationally by position.
  always_ff @(posedge clk) begin
    if (wrEn) begin
      wMem[wrAddr] <= wrData;
    end
  end

  assign wRead   = wMem[idx];
  assign prod    = inData * wRead;
  assign prodExt = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign accNext = strb.first ? prodExt : acc + prodExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strb.accept) begin
      acc <= accNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strb.last) begin
      result <= accNext;
    end
  end

endmodule

// File: rtl/tmi_datapath.sv
module tmi_datapath
  import tmi_pkg::*;
#(
  parameter int NUM_IN    = 256,
  parameter int NUM_LANES = 8,
  parameter int DATA_W    = 8,
  parameter int WGT_W     = 8,
  localparam int IDX_W  = $clog2(NUM_IN),
  localparam int LANE_W = $clog2(NUM_LANES),
  localparam int ACC_W  = DATA_W + WGT_W + IDX_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strb,
  input  logic [IDX_W-1:0]              idx,
  input  logic signed [DATA_W-1:0]      inData,
  input  logic                          wrEn,
  input  logic [LANE_W-1:0]             wrLane,
  input  logic [IDX_W-1:0]              wrAddr,
  input  logic signed [WGT_W-1:0]       wrData,
  output logic [NUM_LANES*ACC_W-1:0]    resData
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic                    laneWr;
    logic signed [ACC_W-1:0] laneRes;

    assign laneWr = wrEn && (wrLane == LANE_W'(g));

    tmi_lane #(
      .NUM_IN (NUM_IN),
      .DATA_W (DATA_W),
      .WGT_W  (WGT_W)
    ) uLane (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strb),
      .idx    (idx),
      .inData (inData),
      .wrEn   (laneWr),
      .wrAddr (wrAddr),
      .wrData (wrData),
      .result (laneRes)
    );

    assign resData[g*ACC_W +: ACC_W] = laneRes;
  end

endmodule

// File: rtl/tmi_mac_array.sv
module tmi_mac_array
  import tmi_pkg::*;
#(
  parameter int NUM_IN    = 256,
  parameter int NUM_LANES = 8,
  parameter int DATA_W    = 8,
  parameter int WGT_W     = 8,
  localparam int IDX_W  = $clog2(NUM_IN),
  localparam int LANE_W = $clog2(NUM_LANES),
  localparam int ACC_W  = DATA_W + WGT_W + IDX_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic signed [DATA_W-1:0]      inData,
  input  logic                          wrEn,
  input  logic [LANE_W-1:0]             wrLane,
  input  logic [IDX_W-1:0]              wrAddr,
  input  logic signed [WGT_W-1:0]       wrData,
  output logic                          resValid,
  output logic [NUM_LANES*ACC_W-1:0]    resData
);

  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] idx;

  tmi_ctrl #(
    .NUM_IN (NUM_IN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .idx      (idx),
    .resValid (resValid)
  );

  tmi_datapath #(
    .NUM_IN    (NUM_IN),
    .NUM_LANES (NUM_LANES),
    .DATA_W    (DATA_W),
    .WGT_W     (WGT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .idx     (idx),
    .inData  (inData),
    .wrEn    (wrEn),
    .wrLane  (wrLane),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .resData (resData)
  );

endmodule

// File: rtl/tmi_mac_array_chk.sv
module tmi_mac_array_chk #(
  parameter int NUM_IN = 256,
  parameter int RES_W  = 8,
  localparam int CNT_W = $clog2(NUM_IN)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             resValid,
  input logic [RES_W-1:0] resData
);

  // Independent count of accepted samples, used to predict the result pulse.
  logic [CNT_W-1:0] seen;
  logic             lastHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen    <= '0;
      lastHit <= 1'b0;
    end else begin
      lastHit <= inValid && (seen == CNT_W'(NUM_IN - 1));
      if (inValid) begin
        seen <= (seen == CNT_W'(NUM_IN - 1)) ? '0 : seen + 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R1: assert (!resValid && (resData == '0))
        else $error("outputs not cleared during reset");
    end
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_result_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    resValid == lastHit);

  assert_count_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(resData));

endmodule

bind tmi_mac_array tmi_mac_array_chk #(
  .NUM_IN (NUM_IN),
  .RES_W  (NUM_LANES * ACC_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .resValid (resValid),
  .resData  (resData)
);

// File: tb/tmi_mac_array_test.sv
module tmi_mac_array_test;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int M     = 4;
  localparam int DW    = 8;
  localparam int WW    = 8;
  localparam int IW    = $clog2(N);
  localparam int LW    = $clog2(M);
  localparam int ACC_W = DW + WW + IW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic wrEn = 1'b0;
  logic [LW-1:0] wrLane = '0;
  logic [IW-1:0] wrAddr = '0;
  logic signed [WW-1:0] wrData = '0;
  logic resValid;
  logic [M*ACC_W-1:0] resData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic signed [WW-1:0] wt [M][N];
  logic signed [DW-1:0] xv [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmi_mac_array #(
    .NUM_IN (N), .NUM_LANES (M), .DATA_W (DW), .WGT_W (WW)
  ) uut (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inData (inData),
    .wrEn (wrEn), .wrLane (wrLane), .wrAddr (wrAddr), .wrData (wrData),
    .resValid (resValid), .resData (resData)
  );

  function automatic longint expLane(int l);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(xv[k]) * longint'(wt[l][k]);
    return s;
  endfunction

  function automatic longint gotLane(int l);
    logic signed [ACC_W-1:0] g;
    g = resData[l*ACC_W +: ACC_W];
    return longint'(g);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic loadW(int l, int a, logic signed [WW-1:0] v);
    wrEn = 1'b1; wrLane = LW'(l); wrAddr = IW'(a); wrData = v;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    wt[l][a] = v;
  endtask

  task automatic loadAllRandom();
    for (int l = 0; l < M; l++)
      for (int k = 0; k < N; k++) loadW(l, k, WW'($urandom));
  endtask

  task automatic loadAllConst(logic signed [WW-1:0] v);
    for (int l = 0; l < M; l++)
      for (int k = 0; k < N; k++) loadW(l, k, v);
  endtask

  // Sends xv; gap idle cycles after every even element; optional write of
  // lane 0 at position hotK on the edge that consumes that position.
  task automatic sendVec(int gap, bit keepBusy, int hotK,
                         logic signed [WW-1:0] hotVal, string req);
    longint exp [M];
    for (int l = 0; l < M; l++) exp[l] = expLane(l);
    for (int k = 0; k < N; k++) begin
      inData = xv[k]; inValid = 1'b1;
      if (k == hotK) begin
        wrEn = 1'b1; wrLane = '0; wrAddr = IW'(k); wrData = hotVal;
      end
      @(posedge clk); @(negedge clk);
      wrEn = 1'b0;
      if (k < N-1) begin
        check(resValid == 1'b0, "R4", "early resValid", longint'(resValid), 0);
        if (gap > 0 && (k % 2 == 0)) begin
          inValid = 1'b0; inData = DW'($urandom);
          repeat (gap) begin @(posedge clk); @(negedge clk); end
        end
      end
    end
    check(resValid == 1'b1, "R4", "resValid after last sample", longint'(resValid), 1);
    for (int l = 0; l < M; l++)
      check(gotLane(l) == exp[l], req, $sformatf("lane %0d total", l), gotLane(l), exp[l]);
    if (hotK >= 0) wt[0][hotK] = hotVal;
    if (!keepBusy) begin
      inValid = 1'b0; inData = DW'($urandom);
    end
  endtask

  task automatic randX();
    for (int k = 0; k < N; k++) xv[k] = DW'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [M*ACC_W-1:0] held;
    #1;
    check(resValid == 1'b0, "R1", "resValid in reset", longint'(resValid), 0);
    check(resData == '0, "R1", "resData in reset", longint'(resData != '0), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R3: random weights and samples, no gaps.
    loadAllRandom();
    randX();
    sendVec(0, 0, -1, '0, "R3");

    // R5 and R9: idle with junk samples and a weight write; result held.
    @(posedge clk); @(negedge clk);
    held = resData;
    for (int i = 0; i < 4; i++) begin
      inData = DW'($urandom);
      if (i == 1) loadW(1, 0, WW'($urandom));
      else begin @(posedge clk); @(negedge clk); end
      check(resValid == 1'b0, "R9", "resValid while idle", longint'(resValid), 0);
      check(resData == held, "R5", "resData held", longint'(resData != held), 0);
    end

    // R6: gaps between samples.
    randX();
    sendVec(2, 0, -1, '0, "R6");
    randX();
    sendVec(1, 0, -1, '0, "R6");

    // R7: three vectors back to back with no idle cycle.
    randX();
    sendVec(0, 1, -1, '0, "R7");
    randX();
    sendVec(0, 1, -1, '0, "R7");
    randX();
    sendVec(0, 0, -1, '0, "R7");

    // R8: extreme operands.
    loadAllConst(WW'(-128));
    for (int k = 0; k < N; k++) xv[k] = DW'(-128);
    sendVec(0, 0, -1, '0, "R8");
    check(gotLane(0) == longint'(N) * 16384, "R8", "most negative squared sum",
          gotLane(0), longint'(N) * 16384);
    for (int k = 0; k < N; k++) xv[k] = DW'(127);
    sendVec(0, 0, -1, '0, "R8");

    // R2: a single weight changes only its lane; write on consuming edge is late.
    loadAllRandom();
    randX();
    sendVec(0, 0, -1, '0, "R2");
    loadW(2, 3, WW'(-77));
    sendVec(0, 0, -1, '0, "R2");
    sendVec(0, 0, 5, WW'(99), "R2");
    sendVec(0, 0, -1, '0, "R2");

    // R3 sweep: one nonzero sample at each position picks that weight.
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) xv[k] = '0;
      xv[p] = DW'(p - 5);
      sendVec(0, 0, -1, '0, "R3");
    end

    // R1: reset in the middle of a vector restarts at element 0.
    for (int k = 0; k < 3; k++) begin
      inData = DW'($urandom); inValid = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    inValid = 1'b0;
    rstN = 1'b0;
    #1;
    check(resValid == 1'b0, "R1", "resValid after mid-run reset", longint'(resValid), 0);
    check(resData == '0, "R1", "resData after mid-run reset", longint'(resData != '0), 0);
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    randX();
    sendVec(0, 0, -1, '0, "R1");

    // Mixed sweep of gaps and back-to-back vectors.
    for (int v = 0; v < 20; v++) begin
      randX();
      sendVec(v % 3, (v % 4) == 1, -1, '0, "R3");
    end
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule